// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a one-bit serial stream, sampled on every rising clock edge, and raises a flag each time the four most recent bits read 1, 1, 0, 1 (oldest first). Matches may share bits, so a stream such as 1101101 produces two detections. Two detectors run side by side on the same input, and each drives its own flag.

The state-only detector has five states: `MO_IDLE` (000), `MO_ONE` (001), `MO_ONEONE` (010), `MO_ONEONEZERO` (011) and `MO_MATCH` (100). On a 0 it moves from `MO_IDLE`, `MO_ONE`, `MO_ONEONEZERO` and `MO_MATCH` to `MO_IDLE`, and from `MO_ONEONE` to `MO_ONEONEZERO`. On a 1 it moves from `MO_IDLE` to `MO_ONE`, from `MO_ONE` to `MO_ONEONE`, from `MO_ONEONE` back to `MO_ONEONE`, from `MO_ONEONEZERO` to `MO_MATCH`, and from `MO_MATCH` to `MO_ONEONE`. Its flag is high only in `MO_MATCH`.

The input-aware detector has four states: `ME_IDLE` (00), `ME_ONE` (01), `ME_ONEONE` (10) and `ME_ONEONEZERO` (11). Its moves from the first three states are the same as the other detector's. From `ME_ONEONEZERO` it goes to `ME_IDLE` on a 0 and to `ME_ONE` on a 1. Its flag is high while the state is `ME_ONEONEZERO` and the input is 1, so it rises one cycle before the state-only flag.

Top module: `seq1101_detector`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with reset high puts both detectors in their idle state, discarding any partial match. Both flags read 0 whenever reset is high.
- R2: `hit_mealy` is 1 in a cycle exactly when `bit_in` is 1 and the three bits sampled at the previous three edges since reset were 1, 1, 0 (oldest first).
- R3: `hit_moore` is 1 in the cycle that follows the sampling edge of a final 1 that completes 1, 1, 0, 1. It is 1 for that single cycle only, unless the next bits complete a new match.
- R4: Overlapping matches are each reported. In the stream 1101101 the trailing 1 of the first match starts the second match, so each flag fires twice.
- R5: Whenever `hit_mealy` is 1 in a cycle, `hit_moore` is 1 in the next cycle. `hit_moore` is never 1 unless `hit_mealy` was 1 in the cycle before.
- R6: Near misses produce no detection. This covers 1100, 1001, 0101 and 1111. A run of extra leading 1s, as in 111101, still gives exactly one detection.
- R7: `hit_mealy` follows `bit_in` within a cycle with no clock edge between. `hit_moore` does not change when `bit_in` changes mid-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| reset | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| hit_moore | output | 1 | Match flag that depends on state only |
| hit_mealy | output | 1 | Match flag that depends on state and the current bit |

## Verification
The pattern and the state sets are fixed, so the block has no parameters, and the bench builds it exactly as it is. This fixed size means directed streams can reach every state and every transition of both machines. That includes the `MO_MATCH` to `MO_ONEONE` and `ME_ONEONEZERO` to `ME_ONE` moves that make overlapping matches work. A long random stream, checked against a four-bit history model, then covers the one-cycle lead of the input-aware flag. A mid-cycle change of the input shows that the two flags depend on the input in different ways.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    // State-only detector: flag equals the top state bit.
    typedef enum logic [2:0] {
        MO_IDLE        = 3'b000,
        MO_ONE         = 3'b001,
        MO_ONEONE      = 3'b010,
        MO_ONEONEZERO  = 3'b011,
        MO_MATCH       = 3'b100
    } moore_st_t;

    // Input-aware detector.
    typedef enum logic [1:0] {
        ME_IDLE        = 2'b00,
        ME_ONE         = 2'b01,
        ME_ONEONE      = 2'b10,
        ME_ONEONEZERO  = 2'b11
    } mealy_st_t;

endpackage

// File: rtl/seq1101_moore.sv
module seq1101_moore
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic reset,
    input  logic bit_in,
    output logic hit
);

    moore_st_t state_q;
    moore_st_t state_d;

    // Next-state logic
    always_comb begin
        state_d = MO_IDLE;
        unique case (state_q)
            MO_IDLE:       state_d = bit_in ? MO_ONE        : MO_IDLE;
            MO_ONE:        state_d = bit_in ? MO_ONEONE     : MO_IDLE;
            MO_ONEONE:     state_d = bit_in ? MO_ONEONE     : MO_ONEONEZERO;
            MO_ONEONEZERO: state_d = bit_in ? MO_MATCH      : MO_IDLE;
            MO_MATCH:      state_d = bit_in ? MO_ONEONE     : MO_IDLE;
            default:       state_d = MO_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (reset) state_q <= MO_IDLE;
        else       state_q <= state_d;
    end

    // Output: state only
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            MO_MATCH: hit = !reset;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq1101_mealy.sv
module seq1101_mealy
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic reset,
    input  logic bit_in,
    output logic hit
);

    mealy_st_t state_q;
    mealy_st_t state_d;

    // Next-state logic
    always_comb begin
        state_d = ME_IDLE;
        unique case (state_q)
            ME_IDLE:       state_d = bit_in ? ME_ONE    : ME_IDLE;
            ME_ONE:        state_d = bit_in ? ME_ONEONE : ME_IDLE;
            ME_ONEONE:     state_d = bit_in ? ME_ONEONE : ME_ONEONEZERO;
            ME_ONEONEZERO: state_d = bit_in ? ME_ONE    : ME_IDLE;
            default:       state_d = ME_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (reset) state_q <= ME_IDLE;
        else       state_q <= state_d;
    end

    // Output: state and current bit
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            ME_ONEONEZERO: hit = bit_in && !reset;
            default:       hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector (
    input  logic clk,
    input  logic reset,
    input  logic bit_in,
    output logic hit_moore,
    output logic hit_mealy
);

    seq1101_moore u_moore (
        .clk    (clk),
        .reset  (reset),
        .bit_in (bit_in),
        .hit    (hit_moore)
    );

    seq1101_mealy u_mealy (
        .clk    (clk),
        .reset  (reset),
        .bit_in (bit_in),
        .hit    (hit_mealy)
    );

endmodule

// File: rtl/seq1101_detector_chk.sv
module seq1101_detector_chk (
    input logic clk,
    input logic reset,
    input logic bit_in,
    input logic hit_moore,
    input logic hit_mealy
);

    // R1: first cycle after reset is idle for the state-only detector
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (reset)
        $past(reset) |-> !hit_moore);

    // R2: the input-aware flag never fires on a 0
    a_r2_needs_one: assert property (@(posedge clk) disable iff (reset)
        hit_mealy |-> bit_in);

    // R3: a match state lasts one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (reset)
        hit_moore |=> !hit_moore);

    // R4: after a match and a 1, the overlap state cannot complete at once
    a_r4_overlap_path: assert property (@(posedge clk) disable iff (reset)
        (hit_moore && bit_in) |=> !hit_mealy);

    // R5: input-aware flag leads by one cycle
    a_r5_mealy_leads: assert property (@(posedge clk) disable iff (reset)
        hit_mealy |=> hit_moore);

    // R5: state-only flag is always preceded by the input-aware flag
    a_r5_moore_follows: assert property (@(posedge clk) disable iff (reset)
        hit_moore |-> $past(hit_mealy));

endmodule

bind seq1101_detector seq1101_detector_chk u_chk (
    .clk       (clk),
    .reset     (reset),
    .bit_in    (bit_in),
    .hit_moore (hit_moore),
    .hit_mealy (hit_mealy)
);

// File: tb/seq1101_detector_tb.sv
module seq1101_detector_tb;

    logic clk = 1'b0;
    logic reset = 1'b1;
    logic bit_in = 1'b0;
    logic hit_moore;
    logic hit_mealy;

    int checks = 0;
    int errors = 0;
    logic [3:0] hist = 4'b0000;  // bits consumed since reset, newest in bit 0

    always #4 clk = ~clk;  // 125 MHz

    seq1101_detector u_dut (
        .clk       (clk),
        .reset     (reset),
        .bit_in    (bit_in),
        .hit_moore (hit_moore),
        .hit_mealy (hit_mealy)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Hold reset for n edges, driving 1s to show they are discarded (R1).
    task automatic apply_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reset = 1'b1;
            bit_in = 1'b1;
            #1;
            check(hit_moore, 1'b0, "R1 moore in reset");
            check(hit_mealy, 1'b0, "R1 mealy in reset");
            @(posedge clk);
            hist = 4'b0000;
        end
    endtask

    // Drive one bit for one cycle and check both flags against the history model.
    task automatic push(input logic b, input string tag);
        @(negedge clk);
        reset = 1'b0;
        bit_in = b;
        #1;
        check(hit_mealy, ({hist[2:0], b} == 4'b1101), {tag, " mealy"});
        check(hit_moore, (hist == 4'b1101), {tag, " moore"});
        @(posedge clk);
        hist = {hist[2:0], b};
    endtask

    task automatic push_bits(input logic [15:0] bits, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) push(bits[i], tag);
    endtask

    // Count detections of each flag over a stream
    task automatic count_hits(input logic [15:0] bits, input int n, input string tag,
                              input int exp_hits);
        int me = 0;
        int mo = 0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            reset = 1'b0;
            bit_in = bits[i];
            #1;
            if (hit_mealy === 1'b1) me++;
            if (hit_moore === 1'b1) mo++;
            @(posedge clk);
            hist = {hist[2:0], bits[i]};
        end
        @(negedge clk);
        bit_in = 1'b0;
        #1;
        if (hit_moore === 1'b1) mo++;
        @(posedge clk);
        hist = {hist[2:0], 1'b0};
        checks += 2;
        if (me != exp_hits) begin
            errors++;
            $display("FAIL %s mealy count: got %0d expected %0d", tag, me, exp_hits);
        end
        if (mo != exp_hits) begin
            errors++;
            $display("FAIL %s moore count: got %0d expected %0d", tag, mo, exp_hits);
        end
    endtask

    task automatic t_single();
        apply_reset(2);
        push_bits(16'b1101_0, 5, "R2/R3 single");
    endtask

    task automatic t_overlap();
        apply_reset(1);
        count_hits(16'b1101101, 7, "R4 overlap", 2);
        apply_reset(1);
        push_bits(16'b1101101_0, 8, "R4 overlap timing");
    endtask

    task automatic t_near_miss();
        apply_reset(1);
        count_hits(16'b1100_1001, 8, "R6 miss a", 0);
        apply_reset(1);
        count_hits(16'b0101_1111, 8, "R6 miss b", 0);
        apply_reset(1);
        count_hits(16'b111101, 6, "R6 long ones", 1);
    endtask

    task automatic t_reset_mid();
        apply_reset(1);
        push_bits(16'b110, 3, "R1 prefix");
        apply_reset(1);
        push(1'b1, "R1 partial cleared");
        push(1'b0, "R1 partial cleared");
    endtask

    task automatic t_midcycle();
        apply_reset(1);
        push_bits(16'b110, 3, "R7 prefix");
        @(negedge clk);
        bit_in = 1'b1;
        #1;
        check(hit_mealy, 1'b1, "R7 mealy on 1");
        check(hit_moore, 1'b0, "R7 moore on 1");
        #1;
        bit_in = 1'b0;
        #1;
        check(hit_mealy, 1'b0, "R7 mealy follows 0");
        check(hit_moore, 1'b0, "R7 moore unchanged");
        @(posedge clk);
        hist = {hist[2:0], 1'b0};
        push(1'b0, "R7 after");
    endtask

    task automatic t_random();
        apply_reset(1);
        for (int i = 0; i < 3000; i++) push(1'($urandom_range(0, 1)), "R5 random");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        apply_reset(1);  // reset state check, R1
        t_single();
        t_overlap();
        t_near_miss();
        t_reset_mid();
        t_midcycle();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule